// File: doc/BRIEF.md
# Burst-of-Two Late-Write SRAM Core

This block is a synchronous static memory core with one command port and one shared data path. Each access moves two data words. A command has an enable, a read/write select and a pair address, and is sampled on every rising clock edge. The pair address selects an aligned word pair: beat 0 is the even word and beat 1 is the odd word.

Write data and its per-byte enables arrive on the edge after the write command. They wait in a one-entry write buffer and enter the array on the following edge. A read that hits a pair still held in that buffer returns the buffered bytes where their enables are set, and the array bytes elsewhere.

Read data leaves through an output pipeline. The two beats that a double-rate bus would carry half a cycle apart are shown here side by side on separate beat-0 and beat-1 ports, with a common valid flag. The word is 36 bits with four 9-bit byte lanes, or 18 bits with two lanes, selected by `DATA_W`.

Top module: `bl2_sram_core`

## Requirements
- R1: While reset is asserted and after it is released, `rd_valid` is 0 and both read data ports are 0 until a read command completes its latency. A read still in flight when reset is asserted never raises `rd_valid`.
- R2: A write to pair address A, followed later by a read of A, returns the beat-0 write word on `rd_d0` and the beat-1 write word on `rd_d1`.
- R3: Write enable bit k of `wbe0` (or `wbe1`) gates bits [9k+8:9k] of the beat-0 (or beat-1) word. A lane whose enable is 0 keeps its previous contents, so all-zero enables leave the pair unchanged.
- R4: A read command sampled at clock edge N drives `rd_valid` high, with its data, from edge N+2 until edge N+3. `rd_valid` is high in no other cycle.
- R5: A cycle with `cmd_en` low is a no-operation, whatever `cmd_wr` and `cmd_addr` hold. It produces no read valid, and the data on the following edge changes no array location.
- R6: The write data and enables are taken on the edge after the write command. The data ports are ignored on every edge that does not directly follow a sampled write command.
- R7: A read issued on the cycle right after a write to the same pair returns that write's data, merged per byte lane with the earlier array contents.
- R8: Writes and reads may be issued on consecutive cycles without stalls, and every write in such a run is committed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control pipeline |
| cmd_en | input | 1 | Command enable; low makes the cycle a no-operation |
| cmd_wr | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | ADDR_W | Pair address of the two-beat burst |
| wd0 | input | DATA_W | Write data for beat 0 (even word), one cycle after the command |
| wbe0 | input | DATA_W/9 | Byte-lane enables for beat 0 |
| wd1 | input | DATA_W | Write data for beat 1 (odd word), one cycle after the command |
| wbe1 | input | DATA_W/9 | Byte-lane enables for beat 1 |
| rd_d0 | output | DATA_W | Read data, beat 0 |
| rd_d1 | output | DATA_W | Read data, beat 1 |
| rd_valid | output | 1 | Read beats are valid this cycle |

## Verification
The hardest situation to reach is a read of a pair whose write data has just entered the buffer and is not yet in the array. It only occurs when a write command is followed at once by a read of the same pair. The stimulus table places exactly that pair of commands with partial byte enables, over a pair that already holds known data. A later read of the same pair then confirms that the merged result was also committed. The table also puts disabled cycles with the write select high, followed by junk data, in front of a read of the pair they name. This shows that neither the command nor the junk reaches the array.

// File: rtl/bl2_sram_core.sv
module bl2_sram_core #(
  parameter int DATA_W = 36,
  parameter int ADDR_W = 6,
  localparam int LANES = DATA_W / 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_en,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] wd0,
  input  logic [LANES-1:0]  wbe0,
  input  logic [DATA_W-1:0] wd1,
  input  logic [LANES-1:0]  wbe1,
  output logic [DATA_W-1:0] rd_d0,
  output logic [DATA_W-1:0] rd_d1,
  output logic              rd_valid
);
  localparam int LANE_W = 9;
  localparam int PAIRS  = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_even [PAIRS];
  logic [DATA_W-1:0] mem_odd  [PAIRS];

  logic              a_vld, a_wr;
  logic [ADDR_W-1:0] a_addr;
  logic              b_vld;
  logic [ADDR_W-1:0] b_addr;
  logic [DATA_W-1:0] b_d0, b_d1;
  logic [LANES-1:0]  b_be0, b_be1;
  logic              r_vld;
  logic [DATA_W-1:0] r_d0, r_d1;
  logic [DATA_W-1:0] m_d0, m_d1;

  wire hit  = b_vld && (b_addr == a_addr);
  wire a_rd = a_vld && !a_wr;

  always_comb begin
    m_d0 = mem_even[a_addr];
    m_d1 = mem_odd[a_addr];
    for (int l = 0; l < LANES; l++) begin
      if (hit && b_be0[l]) m_d0[l*LANE_W +: LANE_W] = b_d0[l*LANE_W +: LANE_W];
      if (hit && b_be1[l]) m_d1[l*LANE_W +: LANE_W] = b_d1[l*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld    <= 1'b0;
      a_wr     <= 1'b0;
      a_addr   <= '0;
      b_vld    <= 1'b0;
      b_addr   <= '0;
      b_d0     <= '0;
      b_d1     <= '0;
      b_be0    <= '0;
      b_be1    <= '0;
      r_vld    <= 1'b0;
      r_d0     <= '0;
      r_d1     <= '0;
      rd_valid <= 1'b0;
      rd_d0    <= '0;
      rd_d1    <= '0;
    end else begin
      a_vld  <= cmd_en;
      a_wr   <= cmd_wr;
      a_addr <= cmd_addr;
      b_vld  <= a_vld && a_wr;
      if (a_vld && a_wr) begin
        b_addr <= a_addr;
        b_d0   <= wd0;
        b_d1   <= wd1;
        b_be0  <= wbe0;
        b_be1  <= wbe1;
      end
      r_vld <= a_rd;
      if (a_rd) begin
        r_d0 <= m_d0;
        r_d1 <= m_d1;
      end
      rd_valid <= r_vld;
      if (r_vld) begin
        rd_d0 <= r_d0;
        rd_d1 <= r_d1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (b_vld) begin
      for (int l = 0; l < LANES; l++) begin
        if (b_be0[l]) mem_even[b_addr][l*LANE_W +: LANE_W] <= b_d0[l*LANE_W +: LANE_W];
        if (b_be1[l]) mem_odd[b_addr][l*LANE_W +: LANE_W]  <= b_d1[l*LANE_W +: LANE_W];
      end
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !rd_valid);

  p_valid_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(cmd_en && !cmd_wr, 3));

  p_read_returns_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_wr) |-> ##3 rd_valid);

  p_noop_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_en |-> ##3 !rd_valid);

  p_buffer_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    b_vld |-> $past(cmd_en && cmd_wr, 2));

  p_buffer_drains_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (b_vld && !(a_vld && a_wr)) |=> !b_vld);
endmodule

// File: tb/bl2_sram_core_tb.sv
`timescale 1ns/1ps
module bl2_sram_core_tb_top;
  localparam int DW = 36;
  localparam int AW = 6;
  localparam int NV = 23;
  localparam logic [79:0] J = {36'h5A5A5A5A5, 4'hF, 36'hA5A5A5A5A, 4'hF};

  // vector: [87] en, [86] wr, [85:80] addr, [79:44] wd0, [43:40] wbe0, [39:4] wd1, [3:0] wbe1
  localparam logic [87:0] VEC [0:NV-1] = '{
    {1'b1, 1'b1, 6'd1, J},
    {1'b1, 1'b1, 6'd2, 36'h111111111, 4'hF, 36'h222222222, 4'hF},
    {1'b0, 1'b1, 6'd2, 36'h333333333, 4'hF, 36'h444444444, 4'hF},
    {1'b0, 1'b1, 6'd5, J},
    {1'b1, 1'b0, 6'd1, J},
    {1'b1, 1'b0, 6'd2, J},
    {1'b0, 1'b0, 6'd0, J},
    {1'b1, 1'b1, 6'd1, J},
    {1'b1, 1'b0, 6'd1, 36'hAAAAAAAAA, 4'b0101, 36'hBBBBBBBBB, 4'b1000},
    {1'b1, 1'b1, 6'd3, J},
    {1'b1, 1'b1, 6'd4, 36'hCCCCCCCCC, 4'hF, 36'hDDDDDDDDD, 4'hF},
    {1'b1, 1'b0, 6'd3, 36'hEEEEEEEEE, 4'hF, 36'hFFFFFFFFF, 4'hF},
    {1'b1, 1'b0, 6'd4, J},
    {1'b1, 1'b0, 6'd1, J},
    {1'b0, 1'b1, 6'd1, J},
    {1'b1, 1'b0, 6'd2, J},
    {1'b1, 1'b1, 6'd2, J},
    {1'b1, 1'b0, 6'd2, 36'h0, 4'h0, 36'h0, 4'h0},
    {1'b1, 1'b0, 6'd2, J},
    {1'b1, 1'b0, 6'd1, J},
    {1'b0, 1'b0, 6'd0, J},
    {1'b0, 1'b0, 6'd0, J},
    {1'b0, 1'b0, 6'd0, J}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_en = 1'b0, cmd_wr = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [DW-1:0] wd0 = '0, wd1 = '0;
  logic [3:0]    wbe0 = '0, wbe1 = '0;
  logic [DW-1:0] rd_d0, rd_d1;
  logic          rd_valid;

  int compared = 0;
  int mismatched = 0;

  logic [DW-1:0] sh0 [64];
  logic [DW-1:0] sh1 [64];
  logic          pv  [3];
  logic [DW-1:0] pd0 [3];
  logic [DW-1:0] pd1 [3];
  string         pt  [3];

  always #2 clk = ~clk;

  bl2_sram_core #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .wd0(wd0), .wbe0(wbe0), .wd1(wd1), .wbe1(wbe1),
    .rd_d0(rd_d0), .rd_d1(rd_d1), .rd_valid(rd_valid));

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] d,
                                          input logic [3:0] be);
    logic [DW-1:0] r = old;
    for (int l = 0; l < 4; l++) if (be[l]) r[l*9 +: 9] = d[l*9 +: 9];
    return r;
  endfunction

  function automatic string tag_of(input int i);
    case (i)
      8, 13:   return "R7 R3";
      11, 12:  return "R8";
      17, 18:  return "R3";
      19:      return "R5 R6";
      default: return "R2";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic          pend = 1'b0;
    logic [AW-1:0] pend_a = '0;
    for (int k = 0; k < 3; k++) begin pv[k] = 1'b0; pd0[k] = '0; pd1[k] = '0; pt[k] = ""; end

    repeat (3) @(negedge clk);
    chk("R1", {35'd0, rd_valid}, '0);
    chk("R1", rd_d0, '0);
    chk("R1", rd_d1, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", {35'd0, rd_valid}, '0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      chk("R4 R5", {35'd0, rd_valid}, {35'd0, pv[2]});
      if (pv[2]) begin
        chk(pt[2], rd_d0, pd0[2]);
        chk(pt[2], rd_d1, pd1[2]);
      end
      pv[2] = pv[1]; pd0[2] = pd0[1]; pd1[2] = pd1[1]; pt[2] = pt[1];
      pv[1] = pv[0]; pd0[1] = pd0[0]; pd1[1] = pd1[0]; pt[1] = pt[0];
      {cmd_en, cmd_wr, cmd_addr, wd0, wbe0, wd1, wbe1} = VEC[i];
      if (pend) begin
        sh0[pend_a] = merge(sh0[pend_a], wd0, wbe0);
        sh1[pend_a] = merge(sh1[pend_a], wd1, wbe1);
      end
      pend   = cmd_en && cmd_wr;
      pend_a = cmd_addr;
      pv[0]  = cmd_en && !cmd_wr;
      pd0[0] = sh0[cmd_addr];
      pd1[0] = sh1[cmd_addr];
      pt[0]  = tag_of(i);
    end

    // R1: a read cut off by reset never completes
    @(negedge clk);
    cmd_en = 1'b1; cmd_wr = 1'b0; cmd_addr = 6'd1;
    @(negedge clk);
    cmd_en = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R1", {35'd0, rd_valid}, '0);
    end
    chk("R1", rd_d0, '0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule